// File: doc/BRIEF.md
# Burst Address Counter

This block produces the internal address for one port of a synchronous memory. On each rising clock edge it picks that cycle's address from one of four sources: zero, an externally supplied address, the previous address plus one, or the previous address unchanged. The picked value is registered and presented on `addr_o`. It is the address of the access launched at that edge, and it is also the counter state that the next edge builds on.

Three active-low controls make the choice. A clear input forces zero. A load strobe captures the external address. An advance input steps the counter. The clear wins over the load, and the load wins over the advance. A switch from one source to another never costs a cycle, so a burst can restart at zero or at a new base address on the same edge that performs an access. Chip select plays no part in the block, so the counter keeps stepping when the port is deselected.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is 0.
- R2: When `clr_ni` is low at a rising edge, `addr_o` becomes 0 after that edge, whatever the values of `load_ni`, `adv_ni` and `ext_addr_i`.
- R3: When `clr_ni` is high and `load_ni` is low at a rising edge, `addr_o` takes the value of `ext_addr_i` at that edge, and `adv_ni` has no effect.
- R4: When `clr_ni` and `load_ni` are high and `adv_ni` is low at a rising edge, `addr_o` becomes its previous value plus one.
- R5: When `clr_ni`, `load_ni` and `adv_ni` are all high at a rising edge, `addr_o` keeps its value, and `ext_addr_i` has no effect.
- R6: An advance from the top address (all ones, 2^ADDR_W-1) produces 0.
- R7: No dead cycle follows a clear or a load. An advance on the very next edge yields 1 after a clear and the loaded value plus one after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; everything is captured on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the counter |
| ext_addr_i | input | ADDR_W | External address, captured when the load strobe is low |
| load_ni | input | 1 | Load strobe, active low |
| adv_ni | input | 1 | Advance enable, active low |
| clr_ni | input | 1 | Counter clear, active low; highest priority |
| addr_o | output | ADDR_W | Internal address registered for the current access |

## Verification
The hardest case to reach is the wrap from the all-ones address. Random advances would take 32768 steps to get there, so directed stimulus loads a value just below the top and then advances across the boundary. Random stimulus then lets the clear, load and advance controls collide on the same edge in every combination, with a bias that keeps bursts long enough to matter. A reference model in the bench applies the priority on every edge and is compared against `addr_o`.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;
endpackage

// File: rtl/addr_ctr_sel.sv
module addr_ctr_sel
  import addr_ctr_pkg::*;
(
  input  logic clr_ni,
  input  logic load_ni,
  input  logic adv_ni,
  output src_e src_o
);
  // clear > load > advance > hold
  always_comb begin
    if (!clr_ni)       src_o = SRC_ZERO;
    else if (!load_ni) src_o = SRC_EXT;
    else if (!adv_ni)  src_o = SRC_INC;
    else               src_o = SRC_HOLD;
  end
endmodule

// File: rtl/addr_ctr_next.sv
module addr_ctr_next
  import addr_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  src_e              src_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] ext_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] inc;
  assign inc = cur_i + ONE;  // natural wrap at top

  always_comb begin
    unique case (src_i)
      SRC_ZERO: nxt_o = '0;
      SRC_EXT:  nxt_o = ext_i;
      SRC_INC:  nxt_o = inc;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/addr_ctr_reg.sv
module addr_ctr_reg #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import addr_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              load_ni,
  input  logic              adv_ni,
  input  logic              clr_ni,
  output logic [ADDR_W-1:0] addr_o
);
  src_e              src;
  logic [ADDR_W-1:0] nxt;

  addr_ctr_sel u_sel (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .adv_ni  (adv_ni),
    .src_o   (src)
  );

  addr_ctr_next #(.ADDR_W(ADDR_W)) u_next (
    .src_i (src),
    .cur_i (addr_o),
    .ext_i (ext_addr_i),
    .nxt_o (nxt)
  );

  addr_ctr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (addr_o)
  );
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              load_ni,
  input logic              adv_ni,
  input logic              clr_ni,
  input logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!rst_ni) AST_RST_ZERO: assert (addr_o == '0); // R1
  end

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> addr_o == '0); // R2
  AST_LOAD_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> addr_o == $past(ext_addr_i)); // R3
  AST_ADV_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !adv_ni |=> addr_o == $past(addr_o) + ONE); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && adv_ni |=> $stable(addr_o)); // R5
  AST_WRAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !adv_ni && (&addr_o) |=> addr_o == '0); // R6
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_addr_i (ext_addr_i),
  .load_ni    (load_ni),
  .adv_ni     (adv_ni),
  .clr_ni     (clr_ni),
  .addr_o     (addr_o)
);

// File: tb/burst_addr_ctr_tb_top.sv
module burst_addr_ctr_tb_top;
  localparam int unsigned AW = 15;
  localparam logic [AW-1:0] TOP = '1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          load_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          clr_ni = 1'b1;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] model = '0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  burst_addr_ctr #(.ADDR_W(AW)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .ext_addr_i (ext_addr_i),
    .load_ni (load_ni), .adv_ni (adv_ni), .clr_ni (clr_ni), .addr_o (addr_o)
  );

  function automatic logic [AW-1:0] ref_next(logic [AW-1:0] cur, logic c, logic l,
                                              logic a, logic [AW-1:0] e);
    if (!c)      return '0;
    else if (!l) return e;
    else if (!a) return cur + 1'b1;
    else         return cur;
  endfunction

  function automatic string req_of(logic c, logic l, logic a, logic [AW-1:0] cur);
    if (!c)      return "R2";
    else if (!l) return "R3";
    else if (!a) return (cur == TOP) ? "R6" : "R4";
    else         return "R5";
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%0h expected=%0h", req, addr_o, exp);
    end
  endtask

  task automatic step(logic c, logic l, logic a, logic [AW-1:0] e, string req = "");
    string r;
    @(negedge clk_i);
    clr_ni = c; load_ni = l; adv_ni = a; ext_addr_i = e;
    r = (req == "") ? req_of(c, l, a, model) : req;
    model = ref_next(model, c, l, a, e);
    @(posedge clk_i);
    #1 check(r, model);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: addr_o=%0h expected=done", addr_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk_i);
    #1 check("R1", '0);
    ext_addr_i = 15'h1abc; load_ni = 1'b0;
    @(posedge clk_i);
    #1 check("R1", '0);  // still in reset, load ignored
    @(negedge clk_i); rst_ni = 1'b1; load_ni = 1'b1;

    step(1, 0, 0, 15'h0123);           // R3 load wins over advance
    step(1, 1, 1, 15'h7777);           // R5 hold ignores ext
    step(1, 1, 0, 15'h7777);           // R4
    step(0, 0, 0, 15'h5555);           // R2 clear beats all
    step(1, 1, 0, 15'h5555, "R7");     // 1 right after clear
    step(1, 0, 1, 15'h2000);           // R3
    step(1, 1, 0, 15'h0000, "R7");     // load+1 next edge
    step(1, 0, 1, TOP - 1);
    step(1, 1, 0, 15'h0);              // R4 -> top
    step(1, 1, 0, 15'h0);              // R6 wrap to 0
    step(1, 0, 1, TOP);
    step(1, 1, 0, 15'h0, "R6");
    step(1, 1, 0, 15'h0);

    for (int i = 0; i < 3000; i++) begin
      int unsigned p = $urandom % 100;
      logic c = !(p < 4);
      logic l = !(p >= 4 && p < 14);
      logic a = ($urandom % 4) == 0;
      if (($urandom % 50) == 0) step(1, 0, 1, TOP - AW'($urandom % 3));
      else step(c, l, a, AW'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule